// File: doc/BRIEF.md
# Converter Wake-up Sequencer

This block runs on the host side of a data converter and brings the converter out of a low-power state. When `wake_req` is seen, the block pulls the converter's active-low chip select down. It waits the settling time that the converter needs after chip select falls. It then shifts one SPI write frame that puts the normal-operation code into the power-control register. Finally it holds off `ready` until the converter has had time to power up completely.

Two recovery paths are selected by `nap_mode`, which is sampled when a request is accepted:
- **Deep-sleep path** (`nap_mode` = 0): a 150 µs chip-select wait before the write, then a 1 ms settle.
- **Light-nap path** (`nap_mode` = 1): no chip-select wait, then a 1 µs settle.

All intervals are whole system-clock cycles. They are derived from the `CLK_KHZ` parameter, rounded up. The SPI clock half-period is `SCLK_HALF` system cycles.

There is no data stream through this block. Every pin is a plain control or status level, so there is no valid/ready back-pressure. A request is a level that is sampled on each rising clock edge. It is accepted only while the block is idle or ready.

Top module: `wk_wake_seq`

## Requirements
- R1: During and directly after reset: `csb_n`=1, `sclk`=0, `sdio`=0 and `ready`=0.
- R2: When `wake_req` is high at a clock edge while the block is idle or ready, `csb_n` is low in the following cycle.
- R3: Deep-sleep path: `csb_n` stays low with `sclk` low for exactly CS_CYC+SCLK_HALF cycles before the first SCLK rise. CS_CYC = ceil(CLK_KHZ*150/1000).
- R4: Frame structure:
  - The frame has 24 bits, sent MSB first, and is sampled on SCLK rising.
  - Bit 23 = 0 (write). Bits 22:8 = register address 25. Bits 7:0 = 8'h02, which is pattern 001x in the low nibble with x driven 0. The whole frame is 24'h001902.
  - SCLK idles low, and each SCLK phase lasts SCLK_HALF cycles.
  - SDIO is stable while SCLK is high.
- R5: `csb_n` returns high exactly one cycle after the last SCLK fall. SCLK and SDIO never toggle while `csb_n` is high.
- R6: Deep-sleep path: `ready` rises exactly SLEEP_CYC = CLK_KHZ cycles after `csb_n` rises.
- R7: Light-nap path: there is no chip-select wait, so the first SCLK rise comes SCLK_HALF cycles after `csb_n` falls. `ready` rises NAP_CYC = ceil(CLK_KHZ/1000) cycles after `csb_n` rises.
- R8: `wake_req` during a running sequence is ignored. Exactly one frame is sent, and all timings remain as in R3, R6 and R7.
- R9: `ready` stays high until a new request is accepted. A request accepted in ready drops `ready` in the next cycle and restarts the sequence.
- R10: `nap_mode` only matters at the accepting edge. Changes during a sequence do not alter its path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Wake request level, sampled each edge |
| nap_mode | input | 1 | 1 selects light-nap recovery, 0 deep-sleep |
| csb_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | SPI serial clock, idle low |
| sdio | output | 1 | SPI serial data out, MSB first |
| ready | output | 1 | Converter fully powered and usable |

## Verification
The bench counts exact cycle distances:
- **Chip-select fall to first SCLK rise.** An off-by-one timer load shows up as a count of CS_CYC+SCLK_HALF±1. A nap path that wrongly kept the chip-select wait would be off by thousands of cycles.
- **Chip-select rise to `ready`.** The bench checks that the settle matches the path chosen at acceptance. This catches a design that re-reads `nap_mode` mid-sequence.

The bench also decodes every frame on the SCLK rising edges. Swapped address or data fields, a wrong don't-care bit, or a frame that is restarted by a stray request all show up as a wrong 24-bit value or a bit count other than 24. Stray requests and toggling `nap_mode` are injected during running sequences. A request accepted from ready must drop `ready` immediately. The bench also checks the single trailing cycle between the last SCLK fall and the chip-select release.

// File: rtl/wk_pkg.sv
package wk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CSWAIT = 3'd1,
    ST_WRITE  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_READY  = 3'd4
  } wk_state_e;

  localparam int FRAME_W    = 24;
  localparam int ADDR_W     = 15;
  localparam int DATA_W     = 8;
  localparam int PWR_REG    = 25;
  localparam logic [DATA_W-1:0] RUN_CODE = 8'h02;

  // write frame: direction bit, address field, data byte
  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] data
  );
    return {1'b0, addr, data};
  endfunction

endpackage

// File: rtl/wk_timer.sv
module wk_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/wk_spi_tx.sv
module wk_spi_tx
  import wk_pkg::*;
#(
  parameter int SCLK_HALF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [FRAME_W-1:0] frame,
  output logic               sclk,
  output logic               sdio,
  output logic               done
);
  localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam int BW = $clog2(FRAME_W);
  localparam logic [DW-1:0] DIV_LAST = DW'(SCLK_HALF - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);

  logic               active_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BW-1:0]      bit_q;
  logic [DW-1:0]      div_q;
  logic               sclk_q;
  logic               done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sh_q     <= '0;
      bit_q    <= '0;
      div_q    <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !active_q) begin
        active_q <= 1'b1;
        sh_q     <= frame;
        bit_q    <= '0;
        div_q    <= DIV_LAST;
        sclk_q   <= 1'b0;
      end else if (active_q) begin
        if (div_q == '0) begin
          div_q <= DIV_LAST;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
            if (bit_q == BIT_LAST) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign sdio = active_q & sh_q[FRAME_W-1];
  assign done = done_q;
endmodule

// File: rtl/wk_seq_fsm.sv
module wk_seq_fsm
  import wk_pkg::*;
#(
  parameter int CS_CYC    = 30000,
  parameter int SLEEP_CYC = 200000,
  parameter int NAP_CYC   = 200,
  parameter int CW        = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wake_req,
  input  logic          nap_mode,
  input  logic          tmr_zero,
  input  logic          spi_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          spi_go,
  output logic          csb_n,
  output logic          ready
);
  wk_state_e state_q, state_d;
  logic      nap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      nap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if ((state_q == ST_IDLE || state_q == ST_READY) && wake_req)
        nap_q <= nap_mode;
    end
  end

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    spi_go   = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_READY: begin
        if (wake_req) begin
          if (nap_mode) begin
            state_d = ST_WRITE;
            spi_go  = 1'b1;
          end else begin
            state_d  = ST_CSWAIT;
            tmr_load = 1'b1;
            tmr_val  = CW'(CS_CYC - 1);
          end
        end
      end
      ST_CSWAIT: begin
        if (tmr_zero) begin
          state_d = ST_WRITE;
          spi_go  = 1'b1;
        end
      end
      ST_WRITE: begin
        if (spi_done) begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = nap_q ? CW'(NAP_CYC - 1) : CW'(SLEEP_CYC - 1);
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) state_d = ST_READY;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign csb_n = !(state_q == ST_CSWAIT || state_q == ST_WRITE);
  assign ready = (state_q == ST_READY);
endmodule

// File: rtl/wk_wake_seq.sv
module wk_wake_seq
  import wk_pkg::*;
#(
  parameter int CLK_KHZ   = 200000,
  parameter int SCLK_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wake_req,
  input  logic nap_mode,
  output logic csb_n,
  output logic sclk,
  output logic sdio,
  output logic ready
);
  localparam int CS_CYC    = (CLK_KHZ * 150 + 999) / 1000;
  localparam int SLEEP_CYC = CLK_KHZ;
  localparam int NAP_CYC   = (CLK_KHZ + 999) / 1000;
  localparam int MAX_CYC   = (SLEEP_CYC > CS_CYC) ? SLEEP_CYC : CS_CYC;
  localparam int CW        = $clog2(MAX_CYC + 1);
  localparam logic [FRAME_W-1:0] WAKE_FRAME =
    build_frame(ADDR_W'(PWR_REG), RUN_CODE);

  logic          tmr_load, tmr_zero, spi_go, spi_done;
  logic [CW-1:0] tmr_val;

  wk_seq_fsm #(
    .CS_CYC(CS_CYC), .SLEEP_CYC(SLEEP_CYC), .NAP_CYC(NAP_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .nap_mode(nap_mode),
    .tmr_zero(tmr_zero), .spi_done(spi_done), .tmr_load(tmr_load),
    .tmr_val(tmr_val), .spi_go(spi_go), .csb_n(csb_n), .ready(ready)
  );

  wk_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  wk_spi_tx #(.SCLK_HALF(SCLK_HALF)) u_spi (
    .clk(clk), .rst_n(rst_n), .go(spi_go), .frame(WAKE_FRAME),
    .sclk(sclk), .sdio(sdio), .done(spi_done)
  );
endmodule

// File: rtl/wk_wake_seq_chk.sv
module wk_wake_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wake_req,
  input logic nap_mode,
  input logic csb_n,
  input logic sclk,
  input logic sdio,
  input logic ready
);
  // R5
  sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !csb_n);

  // R5
  sdio_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdio |-> !csb_n);

  // R4
  sdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdio));

  // R4
  cs_fall_idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csb_n) |-> !sclk);

  // R9
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !wake_req) |=> ready);

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && wake_req) |=> (!ready && !csb_n));
endmodule

bind wk_wake_seq wk_wake_seq_chk u_chk (.*);

// File: tb/wk_wake_seq_bench.sv
module wk_wake_seq_bench;
  localparam int CLK_KHZ   = 10000;
  localparam int SCLK_HALF = 3;
  localparam int CS_EXP    = (CLK_KHZ * 150 + 999) / 1000;
  localparam int SLEEP_EXP = CLK_KHZ;
  localparam int NAP_EXP   = (CLK_KHZ + 999) / 1000;
  localparam logic [23:0] FRAME_EXP = {1'b0, 15'd25, 8'h02};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_req = 1'b0;
  logic nap_mode = 1'b0;
  logic csb_n, sclk, sdio, ready;
  int   n_run = 0;
  int   n_fail = 0;
  int   cyc = 0;

  always #2.5 clk = ~clk;

  wk_wake_seq #(.CLK_KHZ(CLK_KHZ), .SCLK_HALF(SCLK_HALF)) u_wk_wake_seq (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .nap_mode(nap_mode),
    .csb_n(csb_n), .sclk(sclk), .sdio(sdio), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lead_exp(input bit nap);
    return nap ? SCLK_HALF : CS_EXP + SCLK_HALF;
  endfunction

  function automatic int settle_exp(input bit nap);
    return nap ? NAP_EXP : SLEEP_EXP;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic run_wake(input bit nap, input bit noisy, input bit from_rdy);
    int lead, tail, settle, nbits;
    bit prev, cur, stab;
    logic [23:0] fr;
    @(negedge clk);
    wake_req = 1'b1;
    nap_mode = nap;
    @(negedge clk);
    wake_req = 1'b0;
    chk(csb_n == 1'b0, "R2 csb low after accept", csb_n, 0);
    if (from_rdy) chk(ready == 1'b0, "R9 ready drops on restart", ready, 0);
    lead = 0;
    while (sclk == 1'b0 && lead < 20000) begin
      lead++;
      @(negedge clk);
      if (noisy) begin
        wake_req = ($urandom % 3) == 0;
        nap_mode = $urandom;
      end
    end
    chk(lead == lead_exp(nap), nap ? "R7 nap lead" : "R3 cs wait lead",
        lead, lead_exp(nap));
    fr = '0; nbits = 0; prev = 1'b0; cur = 1'b0; stab = 1'b1; tail = 0;
    while (csb_n == 1'b0 && nbits < 40) begin
      if (sclk && !prev) begin
        fr = {fr[22:0], sdio};
        cur = sdio;
        nbits++;
        tail = 0;
      end else if (sclk && sdio != cur) begin
        stab = 1'b0;
      end
      if (!sclk) tail++;
      prev = sclk;
      @(negedge clk);
      if (noisy) begin
        wake_req = ($urandom % 3) == 0;
        nap_mode = $urandom;
      end
    end
    wake_req = 1'b0;
    chk(nbits == 24, "R8 one frame bit count", nbits, 24);
    chk(fr == FRAME_EXP, "R4 frame value", fr, FRAME_EXP);
    chk(stab, "R4 sdio stable in sclk high", stab, 1);
    chk(tail == 1, "R5 csb release after last fall", tail, 1);
    settle = 0;
    while (ready == 1'b0 && settle < 20000) begin
      if (csb_n && !sclk && !sdio) settle++;
      @(negedge clk);
    end
    chk(settle == settle_exp(nap), nap ? "R7 nap settle" : "R6 sleep settle",
        settle, settle_exp(nap));
    if (noisy) chk(settle == settle_exp(nap), "R10 path kept", settle,
                   settle_exp(nap));
    repeat (1 + $urandom % 5) @(negedge clk);
    chk(ready == 1'b1, "R9 ready holds", ready, 1);
  endtask

  initial begin
    int sleeps;
    void'($urandom(32'h5eed_0101));
    repeat (3) @(negedge clk);
    chk(csb_n == 1 && sclk == 0 && sdio == 0 && ready == 0, "R1 reset state",
        {csb_n, sclk, sdio, ready}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(csb_n == 1 && ready == 0, "R1 idle after reset", {csb_n, ready}, 2'b10);

    run_wake(1'b0, 1'b0, 1'b0);
    run_wake(1'b1, 1'b0, 1'b1);
    run_wake(1'b0, 1'b1, 1'b1);
    run_wake(1'b1, 1'b1, 1'b1);

    sleeps = 0;
    for (int i = 0; i < 12; i++) begin
      bit nap;
      nap = ($urandom % 4) != 0;
      if (!nap && sleeps >= 3) nap = 1'b1;
      if (!nap) sleeps++;
      repeat ($urandom % 8) @(negedge clk);
      run_wake(nap, ($urandom % 2) == 1, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule